// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the host-facing front end of an 8-input programmable interrupt controller. It decodes host bus cycles: chip select, one address bit, active-low read and write strobes, and an 8-bit data bus split into input, output and output-enable halves for the pad ring. From these it keeps the controller's configuration and command registers. The priority resolver sits beside it and consumes the values it presents.

Before the controller does anything useful, the host writes a setup sequence of two to four bytes. The sequence starts with a setup byte written at address 0 with data bit 4 set. That first byte forces a set of defaults and records two choices: whether the third byte (cascade wiring) is skipped, and whether the fourth byte (mode flags) follows. Later address-1 bytes are routed by a hidden sequencer. When setup is complete, address-1 writes load the mask. Address-0 writes carry either a priority/end-of-interrupt command or a read-select/special-mask command.

Reads at address 1 return the mask. Reads at address 0 return the resolver's request vector, its in-service vector, or a one-shot polled level. Writes take effect only after the write strobe's rising edge has passed through a synchronizer into the block clock.

Top module: `irq_cmd_seq`

## Requirements
- R1: A write at address 0 with data bit 4 = 1 is the first setup byte. It always restarts the sequence, even part-way through one, and `initDone` stays 0 until the sequence completes.
- R2: Accepting the first setup byte forces these values: `maskReg` = 0, `lowestPrio` = 7, `cascadeCfg` = 8'h07, `specialMask` = 0, no poll pending, and address-0 status reads select the request vector.
- R3: In the first setup byte, bit 0 means "mode byte follows" and bit 3 sets `levelTrig`. If bit 0 = 0, then `cpu86Mode`, `autoEoi`, `bufferedMode` and `specialNested` are all forced to 0. The mode byte loads these four flags from bits 0, 1, 3 and 4 respectively.
- R4: Address-1 writes step through the sequence in this order:
  - The vector byte comes first; `vectorBase` takes bits 7:3.
  - The cascade byte comes next and loads `cascadeCfg`. It is skipped when bit 1 of the first byte (single mode) is 1.
  - The mode byte follows only if bit 0 of the first byte was 1.
  - Setup is then done, and every later address-1 write loads `maskReg`.
- R5: After setup, an address-0 write with bits 4 and 3 both 0 loads `prioCmd` and raises `prioCmdPulse` for one cycle. If its bits 7:5 = 3'b110, it also loads `lowestPrio` from bits 2:0. Address-0 writes other than the first setup byte are ignored before setup completes.
- R6: After setup, an address-0 write with bit 4 = 0 and bit 3 = 1 is a read-select command:
  - Bits 1:0 = 2'b10 select the request vector and 2'b11 select the in-service vector; 2'b0x leaves the selection unchanged.
  - Bits 6:5 = 2'b11 set `specialMask` and 2'b10 clear it; other values leave it unchanged.
- R7: A read-select command with bit 2 = 1 sets `pollActive`. The next address-0 read then returns `pollLevel`. The poll clears when that read ends, and later reads return the selected status vector.
- R8: While chip select and the read strobe are both low, `dataOe` = 1 and `dataOut` carries `maskReg` (address 1) or the address-0 status. Otherwise `dataOe` = 0.
- R9: With chip select high, a write changes no register and `dataOe` stays 0.
- R10: A write takes effect on the rising edge of `wrN`. Its result is not visible one cycle after that edge and is visible by four cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSelN | input | 1 | Active-low chip select |
| addr0 | input | 1 | Register address bit |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| dataIn | input | 8 | Data bus, host to block |
| dataOut | output | 8 | Data bus, block to host |
| dataOe | output | 1 | Output enable for the data bus pad |
| reqIn | input | 8 | Request vector from resolver |
| servIn | input | 8 | In-service vector from resolver |
| pollLevel | input | 8 | Polled level word from resolver |
| initDone | output | 1 | Setup sequence complete |
| singleMode | output | 1 | No cascade byte in the sequence |
| levelTrig | output | 1 | Level-triggered inputs selected |
| maskReg | output | 8 | Interrupt mask |
| vectorBase | output | 5 | Vector base bits 7:3 |
| cascadeCfg | output | 8 | Cascade wiring / slave identity |
| cpu86Mode | output | 1 | 16-bit host vector mode |
| autoEoi | output | 1 | Automatic end of interrupt |
| bufferedMode | output | 1 | Buffered bus mode |
| specialNested | output | 1 | Special fully nested mode |
| lowestPrio | output | 3 | Input holding lowest priority |
| prioCmd | output | 8 | Last priority/end-of-interrupt command |
| prioCmdPulse | output | 1 | One-cycle pulse on a new priority command |
| specialMask | output | 1 | Special mask mode |
| pollActive | output | 1 | Poll pending for next read |

## Verification
Most internal state is visible at the ports, so a sequencer that has advanced to the wrong step shows up on the next address-1 write. That byte lands in the wrong output (vector base, cascade, mode flags or mask), and `initDone` rises early or late, four clock cycles after that strobe's rising edge. A stale read selection or a poll that does not clear shows up on the very next address-0 read as the wrong vector on `dataOut`. Defaults that are applied incompletely show up after any restart, because the bench first drives every defaulted register to a non-default value.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
  parameter int DATA_W = 8;
  localparam int PRIO_W = $clog2(DATA_W);
  localparam int VEC_W  = DATA_W - 3;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_ICW2, SEQ_ICW3, SEQ_ICW4, SEQ_READY
  } seqState_e;

  typedef struct packed {
    logic [DATA_W-1:0] wrByte;
    logic icw1;
    logic icw2;
    logic icw3;
    logic icw4;
    logic ocw1;
    logic ocw2;
    logic ocw3;
    logic rdDone;
  } cmdStrobe_t;
endpackage

// File: rtl/irq_cmd_ctrl.sv
module irq_cmd_ctrl
  import irq_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              addr0,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  output cmdStrobe_t        str,
  output logic              initDone,
  output logic              singleMode
);
  logic [SYNC_STAGES:0] wrSync, rdSync;
  logic                 wrRise, rdRise, wrValid;
  logic                 capSel, capA0, rdCapSel, rdCapA0;
  logic [DATA_W-1:0]    capData;
  logic                 ic4Q, singleQ;
  seqState_e            state, nextState;

  // strobe synchronizers and edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSync <= '1;
      rdSync <= '1;
    end else begin
      wrSync <= {wrSync[SYNC_STAGES-1:0], wrN};
      rdSync <= {rdSync[SYNC_STAGES-1:0], rdN};
    end
  end

  assign wrRise = wrSync[SYNC_STAGES-1] & ~wrSync[SYNC_STAGES];
  assign rdRise = rdSync[SYNC_STAGES-1] & ~rdSync[SYNC_STAGES];

  // capture bus while strobe held low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSel   <= 1'b0;
      capA0    <= 1'b0;
      capData  <= '0;
      rdCapSel <= 1'b0;
      rdCapA0  <= 1'b0;
    end else begin
      if (!wrN) begin
        capSel  <= !chipSelN;
        capA0   <= addr0;
        capData <= dataIn;
      end
      if (!rdN) begin
        rdCapSel <= !chipSelN;
        rdCapA0  <= addr0;
      end
    end
  end

  assign wrValid = wrRise & capSel;

  always_comb begin
    str        = '0;
    str.wrByte = capData;
    str.rdDone = rdRise & rdCapSel & !rdCapA0;
    nextState  = state;
    if (wrValid && !capA0 && capData[4]) begin
      str.icw1  = 1'b1;
      nextState = SEQ_ICW2;
    end else if (wrValid && capA0) begin
      case (state)
        SEQ_ICW2: begin
          str.icw2  = 1'b1;
          nextState = !singleQ ? SEQ_ICW3 : (ic4Q ? SEQ_ICW4 : SEQ_READY);
        end
        SEQ_ICW3: begin
          str.icw3  = 1'b1;
          nextState = ic4Q ? SEQ_ICW4 : SEQ_READY;
        end
        SEQ_ICW4: begin
          str.icw4  = 1'b1;
          nextState = SEQ_READY;
        end
        SEQ_READY: str.ocw1 = 1'b1;
        default: ;
      endcase
    end else if (wrValid && state == SEQ_READY) begin
      if (capData[3]) str.ocw3 = 1'b1;
      else            str.ocw2 = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      ic4Q    <= 1'b0;
      singleQ <= 1'b0;
    end else begin
      state <= nextState;
      if (str.icw1) begin
        ic4Q    <= capData[0];
        singleQ <= capData[1];
      end
    end
  end

  assign initDone   = (state == SEQ_READY);
  assign singleMode = singleQ;

  AST_ICW1_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    str.icw1 |=> (state == SEQ_ICW2)); // R1
  AST_SINGLE_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (str.icw2 && singleQ) |=> (state != SEQ_ICW3)); // R4
  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.icw1, str.icw2, str.icw3, str.icw4, str.ocw1, str.ocw2, str.ocw3})); // R5
endmodule

// File: rtl/irq_cmd_regs.sv
module irq_cmd_regs
  import irq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        str,
  input  logic              chipSelN,
  input  logic              addr0,
  input  logic              rdN,
  input  logic [DATA_W-1:0] reqIn,
  input  logic [DATA_W-1:0] servIn,
  input  logic [DATA_W-1:0] pollLevel,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              levelTrig,
  output logic [DATA_W-1:0] maskReg,
  output logic [VEC_W-1:0]  vectorBase,
  output logic [DATA_W-1:0] cascadeCfg,
  output logic              cpu86Mode,
  output logic              autoEoi,
  output logic              bufferedMode,
  output logic              specialNested,
  output logic [PRIO_W-1:0] lowestPrio,
  output logic [DATA_W-1:0] prioCmd,
  output logic              prioCmdPulse,
  output logic              specialMask,
  output logic              pollActive
);
  localparam logic [PRIO_W-1:0] PRIO_LAST = PRIO_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] SLAVE_DEF = DATA_W'(DATA_W - 1);
  logic readIsr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelTrig     <= 1'b0;
      maskReg       <= '0;
      vectorBase    <= '0;
      cascadeCfg    <= SLAVE_DEF;
      cpu86Mode     <= 1'b0;
      autoEoi       <= 1'b0;
      bufferedMode  <= 1'b0;
      specialNested <= 1'b0;
      lowestPrio    <= PRIO_LAST;
      prioCmd       <= '0;
      prioCmdPulse  <= 1'b0;
      specialMask   <= 1'b0;
      pollActive    <= 1'b0;
      readIsr       <= 1'b0;
    end else begin
      prioCmdPulse <= str.ocw2;
      if (str.rdDone) pollActive <= 1'b0;
      if (str.icw1) begin
        maskReg     <= '0;
        lowestPrio  <= PRIO_LAST;
        cascadeCfg  <= SLAVE_DEF;
        specialMask <= 1'b0;
        readIsr     <= 1'b0;
        pollActive  <= 1'b0;
        levelTrig   <= str.wrByte[3];
        if (!str.wrByte[0]) begin
          cpu86Mode     <= 1'b0;
          autoEoi       <= 1'b0;
          bufferedMode  <= 1'b0;
          specialNested <= 1'b0;
        end
      end
      if (str.icw2) vectorBase <= str.wrByte[DATA_W-1:3];
      if (str.icw3) cascadeCfg <= str.wrByte;
      if (str.icw4) begin
        cpu86Mode     <= str.wrByte[0];
        autoEoi       <= str.wrByte[1];
        bufferedMode  <= str.wrByte[3];
        specialNested <= str.wrByte[4];
      end
      if (str.ocw1) maskReg <= str.wrByte;
      if (str.ocw2) begin
        prioCmd <= str.wrByte;
        if (str.wrByte[7:5] == 3'b110) lowestPrio <= str.wrByte[PRIO_W-1:0];
      end
      if (str.ocw3) begin
        if (str.wrByte[1]) readIsr <= str.wrByte[0];
        if (str.wrByte[6]) specialMask <= str.wrByte[5];
        if (str.wrByte[2]) pollActive <= 1'b1;
      end
    end
  end

  always_comb begin
    dataOe  = !chipSelN && !rdN;
    dataOut = '0;
    if (dataOe) begin
      if (addr0)           dataOut = maskReg;
      else if (pollActive) dataOut = pollLevel;
      else if (readIsr)    dataOut = servIn;
      else                 dataOut = reqIn;
    end
  end

  AST_ICW1_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    str.icw1 |=> (maskReg == '0 && lowestPrio == PRIO_LAST && cascadeCfg == SLAVE_DEF
                  && !specialMask && !readIsr && !pollActive)); // R2
  AST_NO_IC4_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (str.icw1 && !str.wrByte[0]) |=> !(cpu86Mode || autoEoi || bufferedMode || specialNested)); // R3
  AST_POLL_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (str.rdDone && !str.ocw3) |=> !pollActive); // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!str.icw1 && !str.ocw1) |=> $stable(maskReg)); // R9
endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
  import irq_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              addr0,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  input  logic [DATA_W-1:0] reqIn,
  input  logic [DATA_W-1:0] servIn,
  input  logic [DATA_W-1:0] pollLevel,
  output logic              initDone,
  output logic              singleMode,
  output logic              levelTrig,
  output logic [DATA_W-1:0] maskReg,
  output logic [VEC_W-1:0]  vectorBase,
  output logic [DATA_W-1:0] cascadeCfg,
  output logic              cpu86Mode,
  output logic              autoEoi,
  output logic              bufferedMode,
  output logic              specialNested,
  output logic [PRIO_W-1:0] lowestPrio,
  output logic [DATA_W-1:0] prioCmd,
  output logic              prioCmdPulse,
  output logic              specialMask,
  output logic              pollActive
);
  cmdStrobe_t cmdStr;

  irq_cmd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .addr0(addr0), .rdN(rdN),
    .wrN(wrN), .dataIn(dataIn), .str(cmdStr), .initDone(initDone),
    .singleMode(singleMode)
  );

  irq_cmd_regs i_regs (
    .clk(clk), .rstN(rstN), .str(cmdStr), .chipSelN(chipSelN), .addr0(addr0),
    .rdN(rdN), .reqIn(reqIn), .servIn(servIn), .pollLevel(pollLevel),
    .dataOut(dataOut), .dataOe(dataOe), .levelTrig(levelTrig),
    .maskReg(maskReg), .vectorBase(vectorBase), .cascadeCfg(cascadeCfg),
    .cpu86Mode(cpu86Mode), .autoEoi(autoEoi), .bufferedMode(bufferedMode),
    .specialNested(specialNested), .lowestPrio(lowestPrio), .prioCmd(prioCmd),
    .prioCmdPulse(prioCmdPulse), .specialMask(specialMask), .pollActive(pollActive)
  );
endmodule

// File: tb/test_irq_cmd_seq.sv
`timescale 1ns/1ps
module test_irq_cmd_seq;
  logic clk = 1'b0, rstN = 1'b0;
  logic chipSelN = 1'b1, addr0 = 1'b0, rdN = 1'b1, wrN = 1'b1;
  logic [7:0] dataIn = '0;
  logic [7:0] reqIn = 8'h5A, servIn = 8'hC3, pollLevel = 8'h84;
  logic [7:0] dataOut, maskReg, cascadeCfg, prioCmd;
  logic dataOe, initDone, singleMode, levelTrig, cpu86Mode, autoEoi;
  logic bufferedMode, specialNested, prioCmdPulse, specialMask, pollActive;
  logic [4:0] vectorBase;
  logic [2:0] lowestPrio;
  int nChecks = 0, nFails = 0, pulseCnt = 0;
  bit finished = 1'b0;

  irq_cmd_seq i_irq_cmd_seq (.*);

  always #4 clk = ~clk;
  always @(posedge clk) if (prioCmdPulse) pulseCnt++;

  // {addr0, data, expInitDone, expMask, expVecBase, expLowestPrio}
  localparam int NVEC = 6;
  localparam logic [25:0] VEC [0:NVEC-1] = '{
    {1'b0, 8'h13, 1'b0, 8'h00, 5'd0, 3'd7},
    {1'b1, 8'h48, 1'b0, 8'h00, 5'd9, 3'd7},
    {1'b1, 8'h1B, 1'b1, 8'h00, 5'd9, 3'd7},
    {1'b1, 8'hA5, 1'b1, 8'hA5, 5'd9, 3'd7},
    {1'b0, 8'hC3, 1'b1, 8'hA5, 5'd9, 3'd3},
    {1'b0, 8'hC6, 1'b1, 8'hA5, 5'd9, 3'd6}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    chipSelN = !sel; addr0 = a; dataIn = d; wrN = 1'b0;
    repeat (2) @(negedge clk);
    wrN = 1'b1;
    repeat (4) @(negedge clk);
    chipSelN = 1'b1;
  endtask

  task automatic busRead(input logic a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    chipSelN = 1'b0; addr0 = a; rdN = 1'b0;
    @(negedge clk);
    d = dataOut; oe = dataOe;
    rdN = 1'b1;
    repeat (4) @(negedge clk);
    chipSelN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    int pc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("R1 reset initDone", initDone, 0);
    check("R2 reset mask", maskReg, 8'h00);
    check("R2 reset lowestPrio", lowestPrio, 7);
    check("R2 reset cascade", cascadeCfg, 8'h07);
    check("R8 reset dataOe", dataOe, 0);

    // table walk: single mode with mode byte, then mask and priority commands
    for (int i = 0; i < NVEC; i++) begin
      busWrite(VEC[i][25], VEC[i][24:17]);
      check("R4 table initDone", initDone, VEC[i][16]);
      check("R4 table mask", maskReg, VEC[i][15:8]);
      check("R4 table vectorBase", vectorBase, VEC[i][7:3]);
      check("R5 table lowestPrio", lowestPrio, VEC[i][2:0]);
    end
    check("R3 mode flags loaded", {cpu86Mode, autoEoi, bufferedMode, specialNested}, 4'hF);
    check("R5 prioCmd", prioCmd, 8'hC6);
    check("R5 pulse count", pulseCnt, 2);

    // R9 chip select inactive
    busWrite(1'b1, 8'hFF, 1'b0);
    check("R9 mask unchanged", maskReg, 8'hA5);
    busWrite(1'b0, 8'h10, 1'b0);
    check("R9 no restart", initDone, 1);

    // R6 / R8 read selection
    busWrite(1'b0, 8'h6B);
    check("R6 special mask set", specialMask, 1);
    busRead(1'b0, rd, oe);
    check("R6 read in-service", rd, 8'hC3);
    check("R8 dataOe during read", oe, 1);
    check("R8 dataOe after read", dataOe, 0);
    busRead(1'b1, rd, oe);
    check("R8 read mask", rd, 8'hA5);
    busWrite(1'b0, 8'h08);
    busRead(1'b0, rd, oe);
    check("R6 select unchanged", rd, 8'hC3);
    busWrite(1'b0, 8'h0A);
    busRead(1'b0, rd, oe);
    check("R6 read request", rd, 8'h5A);
    busWrite(1'b0, 8'h48);
    check("R6 special mask cleared", specialMask, 0);

    // R7 poll
    busWrite(1'b0, 8'h0C);
    check("R7 poll active", pollActive, 1);
    busRead(1'b0, rd, oe);
    check("R7 poll read", rd, 8'h84);
    check("R7 poll cleared", pollActive, 0);
    busRead(1'b0, rd, oe);
    check("R7 read after poll", rd, 8'h5A);

    // R2 / R3 defaults on restart without mode byte
    busWrite(1'b0, 8'h6B);
    busWrite(1'b0, 8'hC2);
    busWrite(1'b0, 8'h18);
    check("R1 restart initDone", initDone, 0);
    check("R2 mask cleared", maskReg, 8'h00);
    check("R2 lowestPrio", lowestPrio, 7);
    check("R2 cascade", cascadeCfg, 8'h07);
    check("R2 special mask", specialMask, 0);
    check("R3 flags cleared", {cpu86Mode, autoEoi, bufferedMode, specialNested}, 4'h0);
    check("R3 levelTrig", levelTrig, 1);
    busRead(1'b0, rd, oe);
    check("R2 status selects request", rd, 8'h5A);

    // R5 commands ignored before setup done
    pc = pulseCnt;
    busWrite(1'b0, 8'h20);
    check("R5 pre-init pulse", pulseCnt, pc);
    check("R5 pre-init prioCmd", prioCmd, 8'hC2);

    // R1 restart mid-sequence, cascade with mode byte
    busWrite(1'b1, 8'h20);
    check("R4 vector", vectorBase, 4);
    busWrite(1'b0, 8'h11);
    check("R1 mid restart", initDone, 0);
    busWrite(1'b1, 8'h30);
    check("R1 vector after restart", vectorBase, 6);
    busWrite(1'b1, 8'h04);
    check("R4 cascade loaded", cascadeCfg, 8'h04);
    check("R4 wait mode byte", initDone, 0);
    busWrite(1'b1, 8'h02);
    check("R4 done after mode", initDone, 1);
    check("R3 autoEoi", autoEoi, 1);

    // R4 cascade without mode byte
    busWrite(1'b0, 8'h10);
    busWrite(1'b1, 8'h08);
    check("R4 cascade path not done", initDone, 0);
    busWrite(1'b1, 8'h80);
    check("R4 cascade path done", initDone, 1);
    check("R4 cascade value", cascadeCfg, 8'h80);
    check("R4 cascade mode", singleMode, 0);

    // R4 single without mode byte
    busWrite(1'b0, 8'h12);
    busWrite(1'b1, 8'h40);
    check("R4 single done", initDone, 1);
    check("R4 single flag", singleMode, 1);
    check("R4 single vector", vectorBase, 8);

    // R10 timing of the write edge
    @(negedge clk);
    chipSelN = 1'b0; addr0 = 1'b1; dataIn = 8'h3C; wrN = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 no effect while low", maskReg, 8'h00);
    wrN = 1'b1;
    @(negedge clk);
    check("R10 not yet visible", maskReg, 8'h00);
    repeat (3) @(negedge clk);
    check("R10 visible after edge", maskReg, 8'h3C);
    chipSelN = 1'b1;

    // R5 / R9 writes ignored before any setup byte
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    busWrite(1'b1, 8'h55);
    check("R9 pre-setup mask", maskReg, 8'h00);
    busWrite(1'b0, 8'h0B);
    check("R5 pre-setup initDone", initDone, 0);
    busRead(1'b0, rd, oe);
    check("R6 pre-setup select", rd, 8'h5A);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule